// File: doc/BRIEF.md
# IOMMU QoS ID Tagging Unit

This block decides which quality-of-service identifiers travel with every memory request that leaves an address-translation unit. Each request carries a resource-control ID, used for capacity allocation, and a monitoring ID, used for usage accounting. A single 32-bit memory-mapped register holds the pair that the translation unit uses for its own housekeeping traffic. Examples of that traffic are the device directory walk, the command, fault and page-request queues, and the unit's own interrupt writes.

Walks that belong to a particular device use the pair held in that device's context instead. These include process-directory lookups, page-table walks of either stage, interrupt-remapping table reads and interrupt-file writes. The device's own accesses after a successful translation also use the context pair. When translation is in Bare mode, no device context is consulted, so every request is tagged from the global register.

The block also checks every context-supplied ID against the implemented width. If a valid context holds an ID wider than that width, the request is dropped and a misconfiguration fault with cause 259 is raised instead.

Top module: `qos_tag_unit`

## Requirements
- R1: After reset the ID register reads as zero, and neither `tag_valid` nor `fault_valid` is asserted.
- R2: The ID register answers only at byte address 624 (0x270). A read at any other address returns zero, and a write at any other address leaves the register unchanged.
- R3: A write at 624 stores `wdata[RCID_W-1:0]` as the resource-control ID and `wdata[16+MCID_W-1:16]` as the monitoring ID. On read, the resource-control ID appears zero-extended in bits 11:0 and the monitoring ID zero-extended in bits 27:16. Bits 15:12, 31:28 and any unimplemented ID bits always read zero.
- R4: A request whose `req_kind` is 0 to 4 (directory walk, fault queue, command queue, page-request queue, own interrupt) or 11 to 15 is tagged with the register's IDs. `tag_valid` and the IDs appear on the clock edge after the request is sampled.
- R5: Outside Bare mode, a request whose `req_kind` is 5 to 9 (process directory, second-stage table, first-stage table, interrupt-remapping table, interrupt file) is tagged with `dc_rcid` and `dc_mcid`. Only the implemented low bits are kept.
- R6: A device access (`req_kind` = 10) is tagged with the context IDs outside Bare mode. When `bare_mode` is 1, it is tagged with the register IDs.
- R7: Outside Bare mode, take a context-kind request (5 to 10) with `dc_valid` = 1 whose `dc_rcid` or `dc_mcid` has a bit set at or above the implemented width. That request produces `fault_valid` = 1 with `fault_cause` = 259 and no tag. Such a request is not faulted when `dc_valid` = 0 or when the feature is disabled.
- R8: A request presented in the cycle right after a register write is tagged with the newly written IDs.
- R9: `cap_qosid` reports 1 when the feature parameter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_qosid | output | 1 | Feature-present capability flag |
| req_valid | input | 1 | Request to classify |
| req_kind | input | 4 | Request class code |
| bare_mode | input | 1 | Translation is in Bare mode |
| dc_valid | input | 1 | Device context is valid |
| dc_rcid | input | ID_W | Context resource-control ID |
| dc_mcid | input | ID_W | Context monitoring ID |
| tag_valid | output | 1 | Tagged request valid |
| tag_rcid | output | ID_W | Resource-control ID attached |
| tag_mcid | output | ID_W | Monitoring ID attached |
| fault_valid | output | 1 | Misconfiguration fault |
| fault_cause | output | 12 | Fault cause code |

## Verification
The bench aims at the class boundaries. These are kinds 4/5 and 10/11, and the device-access kind in and out of Bare mode. A design with an off-by-one decode, or one that ignores Bare mode, would tag those requests with the wrong pair. Oversized IDs are driven with exactly the first unimplemented bit set, in each field separately. This catches a width check that is one bit loose, and it confirms that an invalid context or Bare mode suppresses the fault. Writes carry ones in the reserved and unimplemented bits, and they are also sent to the neighbouring address. This exposes a register that keeps too many bits or decodes a wider window. A write followed at once by a request catches a register path that adds a cycle.

// File: rtl/qos_tag_pkg.sv
package qos_tag_pkg;

    localparam int unsigned FIELD_W   = 12;
    localparam logic [11:0] CAUSE_DDT_MISCONF = 12'd259;

    typedef enum logic [3:0] {
        K_DDT     = 4'd0,
        K_FQ      = 4'd1,
        K_CQ      = 4'd2,
        K_PQ      = 4'd3,
        K_OWN_MSI = 4'd4,
        K_PDT     = 4'd5,
        K_S2PT    = 4'd6,
        K_S1PT    = 4'd7,
        K_MSIPT   = 4'd8,
        K_MRIF    = 4'd9,
        K_DEV     = 4'd10
    } req_kind_e;

    function automatic logic kind_uses_ctx(input logic [3:0] k);
        return (k >= K_PDT) && (k <= K_DEV);
    endfunction

endpackage

// File: rtl/qos_idreg.sv
module qos_idreg #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REG_ADDR = 624,
    parameter int unsigned RCID_W   = 8,
    parameter int unsigned MCID_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [RCID_W-1:0] rcid,
    output logic [MCID_W-1:0] mcid
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    typedef struct packed {
        logic [RCID_W-1:0] rcid;
        logic [MCID_W-1:0] mcid;
    } idreg_t;

    idreg_t st_d, st_q;
    logic   hit;

    always_comb begin
        hit  = (addr == HIT_ADDR);
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.rcid = wdata[RCID_W-1:0];
            st_d.mcid = wdata[16 +: MCID_W];
        end
        rdata = '0;
        if (hit) begin
            rdata[RCID_W-1:0]   = st_q.rcid;
            rdata[16 +: MCID_W] = st_q.mcid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rcid = st_q.rcid;
    assign mcid = st_q.mcid;

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HIT_ADDR) |=> (rcid == $past(wdata[RCID_W-1:0]))) else $error("write lost"); // R3
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != HIT_ADDR) |=> $stable(rcid) && $stable(mcid)) else $error("stray write"); // R2
    AST_WPRI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15:12] == 4'd0) && (rdata[31:28] == 4'd0)) else $error("reserved bits set"); // R3

endmodule

// File: rtl/qos_width_chk.sv
module qos_width_chk #(
    parameter int unsigned ID_W   = 12,
    parameter int unsigned IMPL_W = 8
) (
    input  logic [ID_W-1:0] id,
    output logic            fits
);
    generate
        if (IMPL_W >= ID_W) begin : g_full
            assign fits = 1'b1;
        end else begin : g_part
            assign fits = (id[ID_W-1:IMPL_W] == '0);
        end
    endgenerate
endmodule

// File: rtl/qos_tag_sel.sv
module qos_tag_sel
    import qos_tag_pkg::*;
#(
    parameter int unsigned ID_W   = 12,
    parameter int unsigned RCID_W = 8,
    parameter int unsigned MCID_W = 6,
    parameter bit          QOS_EN = 1'b1
) (
    input  logic [3:0]        kind,
    input  logic              bare,
    input  logic              dc_valid,
    input  logic [ID_W-1:0]   dc_rcid,
    input  logic [ID_W-1:0]   dc_mcid,
    input  logic              rcid_fits,
    input  logic              mcid_fits,
    input  logic [RCID_W-1:0] g_rcid,
    input  logic [MCID_W-1:0] g_mcid,
    output logic [ID_W-1:0]   sel_rcid,
    output logic [ID_W-1:0]   sel_mcid,
    output logic              misconf
);
    logic use_ctx;

    always_comb begin
        use_ctx  = !bare && kind_uses_ctx(kind);
        sel_rcid = '0;
        sel_mcid = '0;
        if (use_ctx) begin
            sel_rcid[RCID_W-1:0] = dc_rcid[RCID_W-1:0];
            sel_mcid[MCID_W-1:0] = dc_mcid[MCID_W-1:0];
        end else begin
            sel_rcid[RCID_W-1:0] = g_rcid;
            sel_mcid[MCID_W-1:0] = g_mcid;
        end
        misconf = QOS_EN && use_ctx && dc_valid && !(rcid_fits && mcid_fits);
    end
endmodule

// File: rtl/qos_tag_unit.sv
module qos_tag_unit
    import qos_tag_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned REG_ADDR = 624,
    parameter int unsigned ID_W     = 12,
    parameter int unsigned RCID_W   = 8,
    parameter int unsigned MCID_W   = 6,
    parameter bit          QOS_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cap_qosid,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              bare_mode,
    input  logic              dc_valid,
    input  logic [ID_W-1:0]   dc_rcid,
    input  logic [ID_W-1:0]   dc_mcid,
    output logic              tag_valid,
    output logic [ID_W-1:0]   tag_rcid,
    output logic [ID_W-1:0]   tag_mcid,
    output logic              fault_valid,
    output logic [11:0]       fault_cause
);
    typedef struct packed {
        logic            tv;
        logic [ID_W-1:0] rcid;
        logic [ID_W-1:0] mcid;
        logic            fv;
        logic [11:0]     cause;
    } out_t;

    logic [RCID_W-1:0] g_rcid;
    logic [MCID_W-1:0] g_mcid;
    logic              rcid_fits, mcid_fits, misconf;
    logic [ID_W-1:0]   sel_rcid, sel_mcid;
    out_t              out_d, out_q;

    qos_idreg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RCID_W(RCID_W), .MCID_W(MCID_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .rcid(g_rcid), .mcid(g_mcid));

    qos_width_chk #(.ID_W(ID_W), .IMPL_W(RCID_W)) u_chk_r (.id(dc_rcid), .fits(rcid_fits));
    qos_width_chk #(.ID_W(ID_W), .IMPL_W(MCID_W)) u_chk_m (.id(dc_mcid), .fits(mcid_fits));

    qos_tag_sel #(.ID_W(ID_W), .RCID_W(RCID_W), .MCID_W(MCID_W), .QOS_EN(QOS_EN)) u_sel (
        .kind(req_kind), .bare(bare_mode), .dc_valid(dc_valid), .dc_rcid(dc_rcid),
        .dc_mcid(dc_mcid), .rcid_fits(rcid_fits), .mcid_fits(mcid_fits),
        .g_rcid(g_rcid), .g_mcid(g_mcid), .sel_rcid(sel_rcid), .sel_mcid(sel_mcid),
        .misconf(misconf));

    always_comb begin
        out_d = '0;
        if (req_valid) begin
            if (misconf) begin
                out_d.fv    = 1'b1;
                out_d.cause = CAUSE_DDT_MISCONF;
            end else begin
                out_d.tv   = 1'b1;
                out_d.rcid = sel_rcid;
                out_d.mcid = sel_mcid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign tag_valid   = out_q.tv;
    assign tag_rcid    = out_q.rcid;
    assign tag_mcid    = out_q.mcid;
    assign fault_valid = out_q.fv;
    assign fault_cause = out_q.cause;
    assign cap_qosid   = QOS_EN;

    AST_FAULT_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_valid && tag_valid)) else $error("fault with tag"); // R7
    AST_FAULT_NEEDS_DC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dc_valid) |=> !fault_valid) else $error("fault without context"); // R7
    AST_GLOBAL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kind_uses_ctx(req_kind)) |=>
        (tag_valid && tag_rcid[RCID_W-1:0] == $past(g_rcid) && tag_mcid[MCID_W-1:0] == $past(g_mcid)))
        else $error("global tag wrong"); // R4
    AST_BARE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bare_mode) |=> (tag_valid && !fault_valid)) else $error("bare fault"); // R6

endmodule

// File: tb/qos_tag_unit_bench.sv
module qos_tag_unit_bench;
    localparam int ADDR_W = 12, ID_W = 12, RCID_W = 8, MCID_W = 6;
    localparam logic [ADDR_W-1:0] A_REG = 12'd624;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr_en = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic cap_qosid;
    logic req_valid = 0, bare_mode = 0, dc_valid = 0;
    logic [3:0] req_kind = '0;
    logic [ID_W-1:0] dc_rcid = '0, dc_mcid = '0, tag_rcid, tag_mcid;
    logic tag_valid, fault_valid;
    logic [11:0] fault_cause;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qos_tag_unit u_qos_tag_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_qosid(cap_qosid),
        .req_valid(req_valid), .req_kind(req_kind), .bare_mode(bare_mode),
        .dc_valid(dc_valid), .dc_rcid(dc_rcid), .dc_mcid(dc_mcid),
        .tag_valid(tag_valid), .tag_rcid(tag_rcid), .tag_mcid(tag_mcid),
        .fault_valid(fault_valid), .fault_cause(fault_cause));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0; reg_addr = A_REG;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        reg_addr = a; #1; chk(req, reg_rdata, exp); reg_addr = A_REG;
    endtask

    // request driven on a negedge, result visible at the following negedge
    task automatic send(input logic [3:0] k, input logic bare, input logic dv,
                        input logic [11:0] r, input logic [11:0] m);
        req_valid = 1; req_kind = k; bare_mode = bare; dc_valid = dv; dc_rcid = r; dc_mcid = m;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic exp_tag(input string req, input logic [11:0] r, input logic [11:0] m);
        chk({req, " valid"}, {31'd0, tag_valid}, 32'd1);
        chk({req, " fault"}, {31'd0, fault_valid}, 32'd0);
        chk({req, " rcid"}, {20'd0, tag_rcid}, {20'd0, r});
        chk({req, " mcid"}, {20'd0, tag_mcid}, {20'd0, m});
    endtask

    task automatic exp_fault(input string req);
        chk({req, " fault"}, {31'd0, fault_valid}, 32'd1);
        chk({req, " cause"}, {20'd0, fault_cause}, 32'd259);
        chk({req, " notag"}, {31'd0, tag_valid}, 32'd0);
    endtask

    task automatic t_reset;
        rd_chk("R1 reg", A_REG, 32'h0);
        chk("R1 tag_valid", {31'd0, tag_valid}, 32'd0);
        chk("R1 fault_valid", {31'd0, fault_valid}, 32'd0);
        chk("R9 cap", {31'd0, cap_qosid}, 32'd1);
    endtask

    task automatic t_map_warl;
        wr(A_REG, 32'hFFFF_FFFF);
        rd_chk("R3 warl", A_REG, 32'h003F_00FF);
        wr(A_REG, 32'h0012_00A5);
        rd_chk("R3 fields", A_REG, 32'h0012_00A5);
        wr(A_REG + 12'd4, 32'h0001_0001);
        rd_chk("R2 neighbour read", A_REG + 12'd4, 32'h0);
        rd_chk("R2 neighbour write ignored", A_REG, 32'h0012_00A5);
        wr(A_REG - 12'd4, 32'h0);
        rd_chk("R2 lower write ignored", A_REG, 32'h0012_00A5);
    endtask

    task automatic t_global;
        send(4'd0, 0, 1, 12'h7, 12'h9); exp_tag("R4 ddt", 12'hA5, 12'h12);
        send(4'd4, 0, 1, 12'hFFF, 12'hFFF); exp_tag("R4 own msi", 12'hA5, 12'h12);
        send(4'd11, 0, 1, 12'hFFF, 12'hFFF); exp_tag("R4 kind11", 12'hA5, 12'h12);
        @(negedge clk);
        chk("R4 single pulse", {31'd0, tag_valid}, 32'd0);
    endtask

    task automatic t_context;
        send(4'd5, 0, 1, 12'h3C, 12'h2B); exp_tag("R5 pdt", 12'h3C, 12'h2B);
        send(4'd9, 0, 1, 12'hFF, 12'h3F); exp_tag("R5 mrif max", 12'hFF, 12'h3F);
        send(4'd10, 0, 1, 12'h11, 12'h22); exp_tag("R6 dev", 12'h11, 12'h22);
        send(4'd10, 1, 1, 12'h11, 12'h22); exp_tag("R6 dev bare", 12'hA5, 12'h12);
        send(4'd7, 1, 1, 12'h100, 12'h40); exp_tag("R6 s1 bare", 12'hA5, 12'h12);
    endtask

    task automatic t_fault;
        send(4'd6, 0, 1, 12'h100, 12'h0); exp_fault("R7 rcid wide");
        send(4'd8, 0, 1, 12'h0, 12'h040); exp_fault("R7 mcid wide");
        send(4'd10, 0, 1, 12'h800, 12'h0); exp_fault("R7 dev wide");
        send(4'd6, 0, 0, 12'h1FF, 12'h07F); exp_tag("R7 invalid ctx", 12'hFF, 12'h3F);
    endtask

    task automatic t_b2b;
        @(negedge clk); reg_wr_en = 1; reg_addr = A_REG; reg_wdata = 32'h0005_0033;
        @(negedge clk); reg_wr_en = 0;
        send(4'd2, 0, 0, 12'h0, 12'h0); exp_tag("R8 write then req", 12'h33, 12'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        reg_addr = A_REG;
        t_reset;
        t_map_warl;
        t_global;
        t_context;
        t_fault;
        t_b2b;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule